// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block multiplies two unsigned, normalized 128-bit mantissas over many clock cycles. It uses a single accumulator. Each cycle the accumulator moves right by one bit and the multiplicand is added when the current multiplier bit is set. Every bit that leaves the bottom of the accumulator is folded into a sticky flag. This lets a downstream rounding stage learn whether the discarded part of the product was nonzero.

The multiplier operand is walked as four 32-bit words, least significant word first. Inside a word the bits are walked upward. A word that is entirely zero is consumed in one cycle by a 32-bit move. In the lowest word the walk begins above the guard bits, which are always zero. In the highest word the walk ends at the leading one, so the result is already scaled back to the mantissa's fixed point. The result is at most one bit too wide, and the exponent logic downstream fixes that with a single right shift. Exponents, rounding and special operands are handled elsewhere.

A request is made by pulsing `start` while the block is idle. The block holds `busy` while it works. It pulses `done` when the product and the sticky flag are ready. Both stay on the outputs until the next accepted request.

Top module: `shiftadd_mant_mul`

## Requirements
- R1: After reset, `busy`, `done`, `prod` and `sticky` are all zero.
- R2: When `start` is high while the block is idle, the operands are captured and the accumulator and sticky flag are cleared. `busy` is high in the next cycle.
- R3: Operand words are packed with word 0 in bits 31:0 and word 3 in bits 127:96. Let L be the bit index (0 to 127) of the highest set bit of `y_mant`, which lies in word 3. When `done` is high, `prod` equals floor(x_mant * y_mant / 2^L).
- R4: When `done` is high, `sticky` is 1 exactly when (x_mant * y_mant) mod 2^L is nonzero.
- R5: The number of cycles with `busy` high is the sum of four word costs. Word 0 costs 1 if zero, otherwise 32 - GUARD (30 by default). Words 1 and 2 each cost 1 if zero, otherwise 32. Word 3 costs h + 1, where h is its highest set bit.
- R6: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after a run. `prod` and `sticky` are valid in that cycle.
- R7: `start` while `busy` is high is ignored. `prod` and `sticky` keep their values from `done` until the next accepted `start`.
- R8: A zero multiplier word shifts the accumulator right by 32 in a single cycle. The top 32 accumulator bits are then zero, and all 32 dropped bits are ORed into the sticky flag.
- R9: For normalized inputs (leading one at bit LEAD_POS of word 3), `prod` is below 2^(L+2). No accumulator step carries out of the 128-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply (accepted only when idle) |
| x_mant | input | 128 | Multiplicand mantissa, word 0 in bits 31:0 |
| y_mant | input | 128 | Multiplier mantissa, guard bits zero, leading one in word 3 |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: result ready |
| prod | output | 128 | Accumulated product mantissa |
| sticky | output | 1 | OR of all bits shifted out of the accumulator |

## Verification
The assertions take for granted that every accepted multiplier has zero guard bits and its leading one exactly at bit LEAD_POS of word 3. Under that assumption the top word is never skipped, no add carries out, and the product stays below four units. The stimulus table uses only such multipliers, while the multiplicands range freely within the same normalized bound. The only start pulse that breaks nothing is issued mid-run, when it must be ignored, and it also carries a normalized multiplier.

// File: rtl/sam_pkg.sv
package sam_pkg;

    // Controller state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    // Accumulator operation for the current cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_STEP = 2'd1,
        OP_SKIP = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic add;
    } ctl_t;

endpackage

// File: rtl/sam_seq.sv
module sam_seq
    import sam_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int GUARD  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [WORD_W*NWORDS-1:0]   y_in,
    output logic                       busy,
    output logic                       done,
    output logic                       load,
    output ctl_t                       ctl
);
    localparam int WI_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int BI_W = $clog2(WORD_W);
    localparam logic [WI_W-1:0] TOP_W   = WI_W'(NWORDS - 1);
    localparam logic [BI_W-1:0] FIRST_B = BI_W'(GUARD);
    localparam logic [BI_W-1:0] LAST_B  = BI_W'(WORD_W - 1);

    st_e                            st_q;
    logic [NWORDS-1:0][WORD_W-1:0]  y_q;
    logic [WI_W-1:0]                w_q;
    logic [BI_W-1:0]                b_q;
    logic                           done_q;

    logic [WORD_W-1:0] cur;
    logic word_start, skip, above_zero, is_top, last;

    always_comb begin
        cur        = y_q[w_q];
        word_start = (w_q == '0) ? (b_q == FIRST_B) : (b_q == '0);
        skip       = word_start && (cur == '0);
        above_zero = ((cur >> b_q) >> 1) == '0;
        is_top     = (w_q == TOP_W);
        last       = is_top && (skip || above_zero);
        ctl.op     = OP_NONE;
        ctl.add    = 1'b0;
        if (st_q == ST_RUN) begin
            ctl.op  = skip ? OP_SKIP : OP_STEP;
            ctl.add = !skip && cur[b_q];
        end
    end

    assign load = start && (st_q == ST_IDLE);
    assign busy = (st_q == ST_RUN);
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            y_q    <= '0;
            w_q    <= '0;
            b_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                y_q  <= y_in;
                w_q  <= '0;
                b_q  <= FIRST_B;
                st_q <= ST_RUN;
            end else if (st_q == ST_RUN) begin
                if (last) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end else if (skip || b_q == LAST_B) begin
                    w_q <= w_q + 1'b1;
                    b_q <= '0;
                end else begin
                    b_q <= b_q + 1'b1;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && start && !last) |=> (st_q == ST_RUN && $stable(y_q))); // R7

    AST_TOP_NOT_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && is_top) |-> !skip); // R5

    AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (y_in[GUARD-1:0] == '0)); // R5

endmodule

// File: rtl/sam_acc.sv
module sam_acc
    import sam_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [WORD_W*NWORDS-1:0]   x_in,
    input  ctl_t                       ctl,
    output logic [WORD_W*NWORDS-1:0]   acc,
    output logic                       sticky
);
    localparam int MANT_W = WORD_W * NWORDS;

    logic [MANT_W-1:0] x_q, acc_q, addend, half;
    logic              stk_q;
    logic [MANT_W:0]   sum;

    always_comb begin
        addend = ctl.add ? x_q : '0;
        half   = acc_q >> 1;
        sum    = {1'b0, half} + {1'b0, addend};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            acc_q <= '0;
            stk_q <= 1'b0;
        end else if (load) begin
            x_q   <= x_in;
            acc_q <= '0;
            stk_q <= 1'b0;
        end else begin
            case (ctl.op)
                OP_STEP: begin
                    acc_q <= sum[MANT_W-1:0];
                    stk_q <= stk_q | acc_q[0];
                end
                OP_SKIP: begin
                    acc_q <= acc_q >> WORD_W;
                    stk_q <= stk_q | (|acc_q[WORD_W-1:0]);
                end
                default: ;
            endcase
        end
    end

    assign acc    = acc_q;
    assign sticky = stk_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_STEP) |-> !sum[MANT_W]); // R9

    AST_SKIP_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (ctl.op == OP_SKIP && !load) |=> (acc_q[MANT_W-1 -: WORD_W] == '0)); // R8

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ctl.op != OP_NONE && stk_q && !load) |=> stk_q); // R4

endmodule

// File: rtl/shiftadd_mant_mul.sv
module shiftadd_mant_mul
    import sam_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NWORDS   = 4,
    parameter int GUARD    = 2,
    parameter int LEAD_POS = 18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [WORD_W*NWORDS-1:0]  x_mant,
    input  logic [WORD_W*NWORDS-1:0]  y_mant,
    output logic                      busy,
    output logic                      done,
    output logic [WORD_W*NWORDS-1:0]  prod,
    output logic                      sticky
);
    localparam int MANT_W  = WORD_W * NWORDS;
    localparam int LEAD_G  = MANT_W - WORD_W + LEAD_POS;

    ctl_t ctl;
    logic load;

    sam_seq #(.WORD_W(WORD_W), .NWORDS(NWORDS), .GUARD(GUARD)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .y_in  (y_mant),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .ctl   (ctl)
    );

    sam_acc #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .x_in   (x_mant),
        .ctl    (ctl),
        .acc    (prod),
        .sticky (sticky)
    );

    AST_Y_NORMALIZED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> ((y_mant >> LEAD_POS_SHIFT()) == 1)); // R3

    AST_BELOW_FOUR: assert property (@(posedge clk) disable iff (rst)
        done |-> ((prod >> (LEAD_G + 2)) == '0)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(prod) && $stable(sticky))); // R7

    function automatic int LEAD_POS_SHIFT();
        return LEAD_G;
    endfunction

endmodule

// File: tb/sim_shiftadd_mant_mul.sv
`timescale 1ns/1ps
module sim_shiftadd_mant_mul;

    typedef struct packed {
        logic [127:0] x;
        logic [127:0] y;
        logic [31:0]  lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{128'h00040000_00000000_00000000_00000000, 128'h00040000_00000000_00000000_00000000, 32'd22},
        '{128'h0007FFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'h0007FFFF_FFFFFFFF_FFFFFFFF_FFFFFFFC, 32'd113},
        '{128'h0005A5A5_12345678_9ABCDEF0_0F1E2D3C, 128'h00050000_12345678_00000000_00000000, 32'd53},
        '{128'h0007FFFF_00000000_00000000_00000001, 128'h00040001_00000000_80000000_00000000, 32'd53},
        '{128'h00040000_00000000_00000000_00000003, 128'h00060000_00000000_00000000_00000004, 32'd51},
        '{128'h00061234_56789ABC_DEF01234_56789ABC, 128'h0004A5A5_DEADBEEF_00000000_CAFEF00C, 32'd82}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] x_mant = '0;
    logic [127:0] y_mant = '0;
    logic         busy, done, sticky;
    logic [127:0] prod;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    shiftadd_mant_mul u0 (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .x_mant (x_mant),
        .y_mant (y_mant),
        .busy   (busy),
        .done   (done),
        .prod   (prod),
        .sticky (sticky)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: full product, truncated at the leading-one index of y
    function automatic void model(input logic [127:0] xv, input logic [127:0] yv,
                                  output logic [127:0] p, output logic s, output int l);
        logic [255:0] full;
        full = {128'b0, xv} * {128'b0, yv};
        l = 96;
        for (int i = 0; i < 32; i++) if (yv[96+i]) l = 96 + i;
        p = 128'(full >> l);
        s = |(full & ((256'd1 << l) - 256'd1));
    endfunction

    task automatic run_op(input logic [127:0] xv, input logic [127:0] yv, input int lat, input bit inject);
        logic [127:0] ep;
        logic         es;
        int           l;
        int           cnt;
        int           guard;
        model(xv, yv, ep, es, l);
        @(negedge clk);
        x_mant = xv; y_mant = yv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", 128'(busy), 128'd1);
        cnt = 0; guard = 0;
        while (!done && guard < 2000) begin
            if (busy) cnt++;
            guard++;
            if (inject && cnt == 5) begin
                x_mant = ~xv; y_mant = 128'h00040000_00000000_0000FFFF_00000000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done === 1'b1, "R6 done seen", 128'(done), 128'd1);
        check(busy === 1'b0, "R6 idle with done", 128'(busy), 128'd0);
        check(cnt == lat, "R5 busy cycles", 128'(cnt), 128'(lat));
        check(prod === ep, inject ? "R7 restart ignored, R3 product" : "R3 product", prod, ep);
        check(sticky === es, "R4 sticky", 128'(sticky), 128'(es));
        check((prod >> (l + 2)) == '0, "R9 below four", prod, ep);
        // R7: hold after done with new operands applied but no start
        x_mant = ~xv; y_mant = ~yv;
        @(negedge clk);
        check(done === 1'b0, "R6 one-cycle done", 128'(done), 128'd0);
        @(negedge clk);
        @(negedge clk);
        check(prod === ep && sticky === es, "R7 result held", prod, ep);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy", 128'(busy), 128'd0);
        check(done === 1'b0, "R1 done", 128'(done), 128'd0);
        check(prod === '0, "R1 prod", prod, 128'd0);
        check(sticky === 1'b0, "R1 sticky", 128'(sticky), 128'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k].x, VECS[k].y, int'(VECS[k].lat), 1'b0);
        end

        // R7: start during a run must not disturb the result or the latency
        run_op(VECS[5].x, VECS[5].y, int'(VECS[5].lat), 1'b1);
        // R2: accumulator cleared after a large product
        run_op(VECS[1].x, VECS[1].y, int'(VECS[1].lat), 1'b0);
        run_op(VECS[0].x, VECS[0].y, int'(VECS[0].lat), 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule